// File: doc/BRIEF.md
# Mailbox Register Transaction Sequencer

This block runs one power-controller register transaction through a command mailbox. A requester hands it an operation (read, write or masked update), up to five 16-bit register addresses and their data bytes through a valid/ready handshake. The sequencer packs addresses and data into 32-bit payload words. It writes only the words the transaction needs into the mailbox write buffer, then issues the command word.

Completion is awaited in one of two ways, chosen per request. Polled mode samples the mailbox status at a fixed interval and gives up after a bounded number of samples. Interrupt mode sets the interrupt-on-completion bit in the command and waits a bounded number of cycles for the completion pulse. The error flag in the status then decides between success and an I/O error. A successful read returns the leading bytes of the mailbox read buffer. All limits are parameters in clock cycles.

Top module: `mbox_txn_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle. A request is taken on a cycle with `req_valid` and `req_ready` both high, and `req_ready` stays low from then until the response has been given.
- R2: Payload byte 2k holds the low byte and byte 2k+1 the high byte of address k, for each address in use. For a write, data byte k follows at payload byte 2n+k, where n is the register count. Payload byte j sits in word j/4 at bits 8*(j%4)+7 down to 8*(j%4). Every payload byte not filled this way is zero.
- R3: A masked update (op 2) ignores `req_count` and uses address 0 only. The value byte (`req_data` bits 7:0) goes to payload byte 2 and the mask byte (bits 15:8) to payload byte 3. The size field is 4.
- R4: The size field is 2n for a read (op 1) and 3n for a write (op 0). A count above MAX_REGS is handled as MAX_REGS.
- R5: Exactly ceil(size/4) payload words are written, at buffer indices 0 upward, one per cycle with no gap. The command write follows in the next cycle, and no other buffer word is touched.
- R6: The command word carries 0xFF in bits 7:0, the interrupt-mode flag in bit 8 and the operation id in bits 15:12 (0 write, 1 read, 2 update). The size is in bits 23:16. All other bits are zero.
- R7: In polled mode, status bit 0 (busy) is sampled every POLL_GAP cycles after the command. The first sample is taken POLL_GAP cycles after it. The first sample with busy clear completes the transaction. If busy is still set on sample number POLL_TRIES, the result is timeout (1).
- R8: In interrupt mode, the sequencer waits up to IRQ_LIMIT cycles after the command for a high `mb_irq`, and samples the status in the cycle after the pulse. If no pulse arrives in that window, the result is timeout (1). A pulse in the last cycle of the window still counts.
- R9: At completion, status bit 1 set gives result I/O error (2). Otherwise the result is ok (0).
- R10: After an ok read, `rsp_rdata` byte k equals read-buffer byte k for k below the count, and the higher bytes are zero. After a write, an update or any failed transaction, `rsp_rdata` is zero.
- R11: `rsp_valid` is a single-cycle pulse, and `req_ready` is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_op | input | 2 | 0 write, 1 read, 2 masked update |
| req_count | input | CNTW | Number of registers |
| req_irq_mode | input | 1 | 1 wait for interrupt, 0 poll status |
| req_addr | input | 16*MAX_REGS | Register addresses, address k in bits 16k+15:16k |
| req_data | input | 8*MAX_REGS | Write bytes, or value then mask for an update |
| mb_wbuf_we | output | 1 | Write-buffer word strobe |
| mb_wbuf_idx | output | IDXW | Write-buffer word index |
| mb_wbuf_data | output | 32 | Write-buffer word |
| mb_cmd_we | output | 1 | Command register strobe |
| mb_cmd_data | output | 32 | Command word |
| mb_status | input | 32 | Mailbox status, bit 0 busy, bit 1 error |
| mb_irq | input | 1 | Completion pulse |
| mb_rbuf_data | input | 8*MAX_REGS | Read-buffer bytes, byte 0 lowest |
| rsp_valid | output | 1 | Response pulse |
| rsp_result | output | 2 | 0 ok, 1 timeout, 2 I/O error |
| rsp_rdata | output | 8*MAX_REGS | Returned read bytes |

## Verification
The bench targets where the payload layout shifts with the operation. One case is a five-register write that spills into a fourth word. Another is a one-register read that fills only half a word, so a design that writes a fixed word count or leaves stale bytes shows up as a sentinel mismatch or a nonzero pad. A count of seven checks the clamp, and an update with a large count checks that the count is ignored. The timeout edges are probed one cycle apart in both modes. Busy clears just in time for the last poll, and then one cycle too late. The pulse lands in the last cycle of the interrupt window, and then one cycle too late. An off-by-one in a counter therefore flips a result. Error completions in both modes confirm that a failed read returns zeros rather than the read buffer.

// File: rtl/mbox_seq_pkg.sv
package mbox_seq_pkg;

    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_READ   = 2'd1,
        OP_UPDATE = 2'd2,
        OP_RSVD   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_TIMEOUT = 2'd1,
        RES_IOERR   = 2'd2,
        RES_RSVD    = 2'd3
    } res_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_KICK,
        ST_WAIT,
        ST_SAMPLE,
        ST_REPLY
    } st_e;

    localparam logic [7:0] MSG_CODE = 8'hFF;
    localparam int BUSY_BIT = 0;
    localparam int ERR_BIT  = 1;

endpackage

// File: rtl/mbox_payload_pack.sv
module mbox_payload_pack
    import mbox_seq_pkg::*;
#(
    parameter int MAX_REGS = 5,
    parameter int WORDS    = 4,
    parameter int IDXW     = 3,
    parameter int CNTW     = 3
) (
    input  op_e                     op,
    input  logic [CNTW-1:0]         count,
    input  logic [MAX_REGS*16-1:0]  addr,
    input  logic [MAX_REGS*8-1:0]   data,
    output logic [WORDS*32-1:0]     words,
    output logic [7:0]              size,
    output logic [IDXW-1:0]         nwords,
    output logic [CNTW-1:0]         cnt_eff
);
    localparam int NBYTES = WORDS * 4;

    logic [7:0] pbyte [NBYTES];

    always_comb begin
        if (op == OP_UPDATE) begin
            cnt_eff = CNTW'(1);
        end else if (int'(count) > MAX_REGS) begin
            cnt_eff = CNTW'(MAX_REGS);
        end else begin
            cnt_eff = count;
        end
    end

    always_comb begin
        for (int j = 0; j < NBYTES; j++) begin
            pbyte[j] = 8'h00;
        end
        for (int k = 0; k < MAX_REGS; k++) begin
            if (k < int'(cnt_eff)) begin
                pbyte[2*k]   = addr[k*16 +: 8];
                pbyte[2*k+1] = addr[k*16+8 +: 8];
            end
        end
        if (op == OP_WRITE) begin
            for (int k = 0; k < MAX_REGS; k++) begin
                if (k < int'(cnt_eff) && (2*int'(cnt_eff) + k) < NBYTES) begin
                    pbyte[2*int'(cnt_eff) + k] = data[k*8 +: 8];
                end
            end
        end else if (op == OP_UPDATE) begin
            pbyte[2] = data[7:0];
            pbyte[3] = data[15:8];
        end
    end

    always_comb begin
        case (op)
            OP_READ:  size = 8'(2 * int'(cnt_eff));
            OP_WRITE: size = 8'(3 * int'(cnt_eff));
            default:  size = 8'd4;
        endcase
        nwords = IDXW'((int'(size) + 3) / 4);
    end

    genvar gj;
    generate
        for (gj = 0; gj < NBYTES; gj++) begin : g_word_bytes
            assign words[gj*8 +: 8] = pbyte[gj];
        end
    endgenerate

endmodule

// File: rtl/mbox_cycle_counter.sv
module mbox_cycle_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt_q
);
    logic [W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/mbox_txn_seq.sv
module mbox_txn_seq
    import mbox_seq_pkg::*;
#(
    parameter int MAX_REGS   = 5,
    parameter int POLL_GAP   = 125,
    parameter int POLL_TRIES = 100000,
    parameter int IRQ_LIMIT  = 375000000,
    localparam int WORDS     = (3 * MAX_REGS + 3) / 4,
    localparam int IDXW      = $clog2(WORDS + 1),
    localparam int CNTW      = $clog2(MAX_REGS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [1:0]              req_op,
    input  logic [CNTW-1:0]         req_count,
    input  logic                    req_irq_mode,
    input  logic [MAX_REGS*16-1:0]  req_addr,
    input  logic [MAX_REGS*8-1:0]   req_data,
    output logic                    mb_wbuf_we,
    output logic [IDXW-1:0]         mb_wbuf_idx,
    output logic [31:0]             mb_wbuf_data,
    output logic                    mb_cmd_we,
    output logic [31:0]             mb_cmd_data,
    input  logic [31:0]             mb_status,
    input  logic                    mb_irq,
    input  logic [MAX_REGS*8-1:0]   mb_rbuf_data,
    output logic                    rsp_valid,
    output logic [1:0]              rsp_result,
    output logic [MAX_REGS*8-1:0]   rsp_rdata
);
    localparam int TMAX = (IRQ_LIMIT > POLL_GAP) ? IRQ_LIMIT : POLL_GAP;
    localparam int TMW  = $clog2(TMAX + 1);
    localparam int TRW  = $clog2(POLL_TRIES + 1);

    typedef struct packed {
        st_e                    st;
        op_e                    op;
        logic [CNTW-1:0]        cnt;
        logic [MAX_REGS*16-1:0] addr;
        logic [MAX_REGS*8-1:0]  data;
        logic                   irqm;
        logic [IDXW-1:0]        widx;
        logic [TRW-1:0]         tries;
        res_e                   res;
        logic [MAX_REGS*8-1:0]  rdata;
    } seq_t;

    seq_t r_q, r_d;

    logic [WORDS*32-1:0] words;
    logic [7:0]          size;
    logic [IDXW-1:0]     nwords;
    logic [CNTW-1:0]     cnt_eff;
    logic                tmr_clr, tmr_inc;
    logic [TMW-1:0]      tmr_q;
    logic                finish;
    logic [31:0]         wsel;

    mbox_payload_pack #(
        .MAX_REGS (MAX_REGS),
        .WORDS    (WORDS),
        .IDXW     (IDXW),
        .CNTW     (CNTW)
    ) u_pack (
        .op      (r_q.op),
        .count   (r_q.cnt),
        .addr    (r_q.addr),
        .data    (r_q.data),
        .words   (words),
        .size    (size),
        .nwords  (nwords),
        .cnt_eff (cnt_eff)
    );

    mbox_cycle_counter #(
        .W (TMW)
    ) u_wait_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .inc   (tmr_inc),
        .cnt_q (tmr_q)
    );

    // Next-state computation
    always_comb begin
        r_d     = r_q;
        tmr_clr = 1'b0;
        tmr_inc = 1'b0;
        finish  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.op    = op_e'(req_op);
                    r_d.cnt   = req_count;
                    r_d.addr  = req_addr;
                    r_d.data  = req_data;
                    r_d.irqm  = req_irq_mode;
                    r_d.widx  = '0;
                    r_d.tries = '0;
                    r_d.res   = RES_OK;
                    r_d.rdata = '0;
                    r_d.st    = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (nwords == '0 || r_q.widx == nwords - IDXW'(1)) begin
                    r_d.st = ST_KICK;
                end
                r_d.widx = r_q.widx + IDXW'(1);
            end
            ST_KICK: begin
                tmr_clr = 1'b1;
                r_d.st  = ST_WAIT;
            end
            ST_WAIT: begin
                if (r_q.irqm) begin
                    if (mb_irq) begin
                        r_d.st = ST_SAMPLE;
                    end else if (tmr_q == TMW'(IRQ_LIMIT - 1)) begin
                        r_d.res = RES_TIMEOUT;
                        r_d.st  = ST_REPLY;
                    end else begin
                        tmr_inc = 1'b1;
                    end
                end else begin
                    if (tmr_q == TMW'(POLL_GAP - 1)) begin
                        tmr_clr = 1'b1;
                        if (!mb_status[BUSY_BIT]) begin
                            finish = 1'b1;
                        end else if (r_q.tries == TRW'(POLL_TRIES - 1)) begin
                            r_d.res = RES_TIMEOUT;
                            r_d.st  = ST_REPLY;
                        end else begin
                            r_d.tries = r_q.tries + TRW'(1);
                        end
                    end else begin
                        tmr_inc = 1'b1;
                    end
                end
            end
            ST_SAMPLE: begin
                finish = 1'b1;
            end
            ST_REPLY: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase

        if (finish) begin
            r_d.st = ST_REPLY;
            if (mb_status[ERR_BIT]) begin
                r_d.res = RES_IOERR;
            end else begin
                r_d.res = RES_OK;
                if (r_q.op == OP_READ) begin
                    for (int k = 0; k < MAX_REGS; k++) begin
                        if (k < int'(cnt_eff)) begin
                            r_d.rdata[k*8 +: 8] = mb_rbuf_data[k*8 +: 8];
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.op    <= OP_WRITE;
            r_q.res   <= RES_OK;
        end else begin
            r_q <= r_d;
        end
    end

    // Word selection for the buffer write port
    always_comb begin
        wsel = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (int'(r_q.widx) == w) begin
                wsel = words[w*32 +: 32];
            end
        end
    end

    assign req_ready    = (r_q.st == ST_IDLE);
    assign mb_wbuf_we   = (r_q.st == ST_LOAD) && (r_q.widx < nwords);
    assign mb_wbuf_idx  = r_q.widx;
    assign mb_wbuf_data = wsel;
    assign mb_cmd_we    = (r_q.st == ST_KICK);
    assign mb_cmd_data  = {8'h00, size, 2'b00, r_q.op, 3'b000, r_q.irqm, MSG_CODE};
    assign rsp_valid    = (r_q.st == ST_REPLY);
    assign rsp_result   = r_q.res;
    assign rsp_rdata    = r_q.rdata;

endmodule

// File: rtl/mbox_txn_seq_chk.sv
module mbox_txn_seq_chk #(
    parameter int MAX_REGS = 5,
    parameter int IDXW     = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_ready,
    input logic                   mb_wbuf_we,
    input logic [IDXW-1:0]        mb_wbuf_idx,
    input logic                   mb_cmd_we,
    input logic [31:0]            mb_cmd_data,
    input logic                   rsp_valid,
    input logic [1:0]             rsp_result,
    input logic [MAX_REGS*8-1:0]  rsp_rdata
);
    AST_NO_STROBE_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(mb_wbuf_we && mb_cmd_we)); // R5

    AST_WORDS_THEN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        mb_wbuf_we |=> (mb_wbuf_we || mb_cmd_we)); // R5

    AST_INDEX_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_wbuf_we && $past(mb_wbuf_we)) |-> (mb_wbuf_idx == $past(mb_wbuf_idx) + 1'b1)); // R5

    AST_CMD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        mb_cmd_we |-> (mb_cmd_data[7:0] == 8'hFF && mb_cmd_data[31:24] == 8'h00)); // R6

    AST_BUSY_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_cmd_we || mb_wbuf_we) |-> !req_ready); // R1

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready)); // R11

    AST_NO_DATA_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_result != 2'd0) |-> (rsp_rdata == '0)); // R10

endmodule

bind mbox_txn_seq mbox_txn_seq_chk #(
    .MAX_REGS (MAX_REGS),
    .IDXW     (IDXW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .mb_wbuf_we  (mb_wbuf_we),
    .mb_wbuf_idx (mb_wbuf_idx),
    .mb_cmd_we   (mb_cmd_we),
    .mb_cmd_data (mb_cmd_data),
    .rsp_valid   (rsp_valid),
    .rsp_result  (rsp_result),
    .rsp_rdata   (rsp_rdata)
);

// File: tb/mbox_txn_seq_test.sv
`timescale 1ns/1ps
module mbox_txn_seq_test;
    localparam int MR    = 5;
    localparam int GAP   = 4;
    localparam int TRIES = 6;
    localparam int ILIM  = 30;
    localparam int WORDS = 4;
    localparam int IDXW  = 3;
    localparam int CNTW  = 3;
    localparam logic [31:0] SENT = 32'hA5A5_5A5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_op = 2'd0;
    logic [CNTW-1:0]   req_count = '0;
    logic              req_irq_mode = 1'b0;
    logic [MR*16-1:0]  req_addr = '0;
    logic [MR*8-1:0]   req_data = '0;
    logic              mb_wbuf_we;
    logic [IDXW-1:0]   mb_wbuf_idx;
    logic [31:0]       mb_wbuf_data;
    logic              mb_cmd_we;
    logic [31:0]       mb_cmd_data;
    logic [31:0]       mb_status;
    logic              mb_irq;
    logic [MR*8-1:0]   mb_rbuf_data;
    logic              rsp_valid;
    logic [1:0]        rsp_result;
    logic [MR*8-1:0]   rsp_rdata;

    mbox_txn_seq #(
        .MAX_REGS   (MR),
        .POLL_GAP   (GAP),
        .POLL_TRIES (TRIES),
        .IRQ_LIMIT  (ILIM)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_op       (req_op),
        .req_count    (req_count),
        .req_irq_mode (req_irq_mode),
        .req_addr     (req_addr),
        .req_data     (req_data),
        .mb_wbuf_we   (mb_wbuf_we),
        .mb_wbuf_idx  (mb_wbuf_idx),
        .mb_wbuf_data (mb_wbuf_data),
        .mb_cmd_we    (mb_cmd_we),
        .mb_cmd_data  (mb_cmd_data),
        .mb_status    (mb_status),
        .mb_irq       (mb_irq),
        .mb_rbuf_data (mb_rbuf_data),
        .rsp_valid    (rsp_valid),
        .rsp_result   (rsp_result),
        .rsp_rdata    (rsp_rdata)
    );

    // Mailbox model
    int           cfg_delay = 0;
    logic         cfg_err = 1'b0;
    logic [MR*8-1:0] cfg_rbuf = '0;
    logic [31:0]  mbuf [WORDS];
    logic [31:0]  snap [WORDS];
    logic [31:0]  snap_cmd;
    int           wr_cnt, snap_cnt, dly;
    logic         busy, err_q, irq_q, ioc_q;

    assign mb_status    = {30'b0, err_q, busy};
    assign mb_irq       = irq_q;
    assign mb_rbuf_data = cfg_rbuf;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) begin
                mbuf[w] <= SENT;
                snap[w] <= '0;
            end
            snap_cmd <= '0; wr_cnt <= 0; snap_cnt <= 0; dly <= 0;
            busy <= 1'b0; err_q <= 1'b0; irq_q <= 1'b0; ioc_q <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (mb_wbuf_we) begin
                mbuf[mb_wbuf_idx[1:0]] <= mb_wbuf_data;
                wr_cnt <= wr_cnt + 1;
            end
            if (mb_cmd_we) begin
                snap_cmd <= mb_cmd_data;
                snap_cnt <= wr_cnt;
                for (int w = 0; w < WORDS; w++) begin
                    snap[w] <= mbuf[w];
                    mbuf[w] <= SENT;
                end
                wr_cnt <= 0;
                busy   <= 1'b1;
                err_q  <= 1'b0;
                dly    <= cfg_delay;
                ioc_q  <= mb_cmd_data[8];
            end else if (busy) begin
                if (dly == 0) begin
                    busy  <= 1'b0;
                    err_q <= cfg_err;
                    irq_q <= ioc_q;
                end else begin
                    dly <= dly - 1;
                end
            end
        end
    end

    // Scoreboard
    typedef struct {
        string       tag;
        logic [31:0] cmd;
        logic [31:0] w [WORDS];
        int          nw;
        logic [1:0]  res;
        logic [MR*8-1:0] rd;
    } exp_t;

    exp_t exp_q [$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   n_rsp = 0;
    bit   done  = 1'b0;

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk("R11 unexpected response", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.tag, " R6 command word"}, 64'(snap_cmd), 64'(e.cmd));
                chk({e.tag, " R5 words written"}, 64'(snap_cnt), 64'(e.nw));
                for (int w = 0; w < WORDS; w++) begin
                    if (w < e.nw) chk({e.tag, " R2 payload word"}, 64'(snap[w]), 64'(e.w[w]));
                    else          chk({e.tag, " R5 untouched word"}, 64'(snap[w]), 64'(SENT));
                end
                chk({e.tag, " R9 result"}, 64'(rsp_result), 64'(e.res));
                chk({e.tag, " R10 read data"}, 64'(rsp_rdata), 64'(e.rd));
            end
            n_rsp++;
        end
    end

    // Driver: computes expectations from the requirements and issues one request
    task automatic run(input string tag, input bit irqm, input int op, input int cnt,
                       input logic [MR*16-1:0] addr, input logic [MR*8-1:0] data,
                       input int delay, input bit err, input logic [MR*8-1:0] rbuf,
                       input int res);
        exp_t e;
        logic [7:0] b [16];
        int ce, size, target;
        ce = (op == 2) ? 1 : ((cnt > MR) ? MR : cnt);
        for (int j = 0; j < 16; j++) b[j] = 8'h00;
        for (int k = 0; k < ce; k++) begin
            b[2*k]   = addr[16*k +: 8];
            b[2*k+1] = addr[16*k+8 +: 8];
        end
        if (op == 0) begin
            for (int k = 0; k < ce; k++) b[2*ce+k] = data[8*k +: 8];
            size = 3 * ce;
        end else if (op == 1) begin
            size = 2 * ce;
        end else begin
            b[2] = data[7:0];
            b[3] = data[15:8];
            size = 4;
        end
        e.tag = tag;
        e.cmd = {8'h00, 8'(size), 4'(op), 3'b000, irqm, 8'hFF};
        for (int w = 0; w < WORDS; w++) e.w[w] = {b[4*w+3], b[4*w+2], b[4*w+1], b[4*w]};
        e.nw  = (size + 3) / 4;
        e.res = 2'(res);
        e.rd  = '0;
        if (res == 0 && op == 1) begin
            for (int k = 0; k < ce; k++) e.rd[8*k +: 8] = rbuf[8*k +: 8];
        end
        exp_q.push_back(e);
        target = n_rsp + 1;

        @(negedge clk);
        cfg_delay    = delay;
        cfg_err      = err;
        cfg_rbuf     = rbuf;
        req_valid    = 1'b1;
        req_op       = 2'(op);
        req_count    = CNTW'(cnt);
        req_irq_mode = irqm;
        req_addr     = addr;
        req_data     = data;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R1 ready low in flight"}, 64'(req_ready), 64'd0);
        while (n_rsp < target) @(negedge clk);
        @(negedge clk);
        chk({tag, " R11 pulse ends and ready"}, {62'd0, rsp_valid, req_ready}, 64'd1);
    endtask

    localparam logic [MR*16-1:0] ADDRS = {16'h0A55, 16'h1234, 16'h00F0, 16'hBEEF, 16'h0102};
    localparam logic [MR*8-1:0]  DATAS = {8'h99, 8'h88, 8'h77, 8'h66, 8'h55};
    localparam logic [MR*8-1:0]  RBUF  = {8'hE5, 8'hD4, 8'hC3, 8'hB2, 8'hA1};

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 / R11 reset state
        chk("R1 reset ready", 64'(req_ready), 64'd1);
        chk("R11 reset no response", 64'(rsp_valid), 64'd0);
        chk("R5 reset no strobes", {62'd0, mb_wbuf_we, mb_cmd_we}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run("R2 poll read one",       0, 1, 1, ADDRS, DATAS, 3, 0, RBUF, 0);
        run("R10 poll read five",     0, 1, 5, ADDRS, DATAS, 2, 0, RBUF, 0);
        run("R4 poll write two",      0, 0, 2, ADDRS, DATAS, 1, 0, RBUF, 0);
        run("R2 poll write five",     0, 0, 5, ADDRS, DATAS, 4, 0, RBUF, 0);
        run("R4 write count clamp",   0, 0, 7, ADDRS, DATAS, 2, 0, RBUF, 0);
        run("R3 poll update",         0, 2, 4, ADDRS, {8'h00, 8'h00, 8'h00, 8'h3C, 8'hC3}, 2, 0, RBUF, 0);
        run("R9 poll read error",     0, 1, 3, ADDRS, DATAS, 2, 1, RBUF, 2);
        run("R7 poll last try ok",    0, 1, 2, ADDRS, DATAS, 22, 0, RBUF, 0);
        run("R7 poll timeout edge",   0, 1, 2, ADDRS, DATAS, 23, 0, RBUF, 1);
        run("R7 poll timeout long",   0, 0, 1, ADDRS, DATAS, 1000, 0, RBUF, 1);
        run("R8 irq read three",      1, 1, 3, ADDRS, DATAS, 5, 0, RBUF, 0);
        run("R9 irq write error",     1, 0, 4, ADDRS, DATAS, 5, 1, RBUF, 2);
        run("R3 irq update",          1, 2, 1, ADDRS, {8'h00, 8'h00, 8'h00, 8'h0F, 8'hAB}, 3, 0, RBUF, 0);
        run("R8 irq last cycle ok",   1, 1, 1, ADDRS, DATAS, 28, 0, RBUF, 0);
        run("R8 irq timeout edge",    1, 1, 1, ADDRS, DATAS, 29, 0, RBUF, 1);
        run("R10 read after timeout", 0, 1, 4, ADDRS, DATAS, 0, 0, ~RBUF, 0);

        chk("R1 queue drained", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule